// File: doc/BRIEF.md
# Packed Byte-Lane Add/Subtract Unit

This unit carries out the byte-wide packed addition and subtraction operations of a scalar core's packed-arithmetic extension. It receives an issue strobe, a 32-bit R-type instruction word and two register-width source operands. It splits both operands into independent 8-bit lanes and decodes one of ten operations: add or subtract, each in one of five flavours. The flavours are wrap-around, signed halving, unsigned halving, signed saturating and unsigned saturating. The unit returns the packed result, a result-valid strobe and an illegal-instruction strobe.

A sticky saturation bit records that a saturating operation had to clamp at least one lane. The bit stays set until the core pulses a clear input. By default the outputs are registered and appear one clock after issue. A parameter can select a combinational output path instead, but the sticky bit is always a register. The register width is a parameter and may be 32 or 64 bits, which gives 4 or 8 lanes.

Top module: `simd8_addsub`

## Requirements
- R1: An issued word is recognised only when bits 6:0 equal 1110111 and bits 14:12 equal 000. In any other cycle, whether the word is unrecognised or nothing is issued, the unit drives res=0, res_vld=0 and illegal=0, and the sticky bit is not set by that cycle.
- R2: For a recognised word, funct7 (bits 31:25) selects the operation. Additions: 0100100 is wrap, 0000100 is signed halving, 0010100 is unsigned halving, 0001100 is signed saturating and 0011100 is unsigned saturating. Subtractions use the same values with bit 25 set to 1. A listed value raises res_vld.
- R3: Lane i occupies bits 8i+7:8i. Its result depends only on lane i of both operands. The wrap operations return the low 8 bits of the lane sum or difference and discard any carry or borrow.
- R4: Signed halving returns bits 8:1 of the exact two's-complement lane sum or difference, which rounds toward minus infinity.
- R5: Unsigned halving returns bits 8:1 of the exact lane sum or difference of the unsigned lanes. A negative difference is taken in two's complement, so 0x00-0x01 gives 0xFF.
- R6: Signed saturating returns the exact lane result clamped to the range -128..127.
- R7: Unsigned saturating returns the exact lane result clamped to the range 0..255, so a subtraction floors at 0x00.
- R8: The sticky bit sets at the clock edge that samples a saturating operation in which any lane was clamped. Wrap and halving operations never set it.
- R9: A high sat_clr clears the sticky bit at the next edge, unless a clamp occurs in that same cycle; in that case the bit stays set. Without sat_clr the bit holds its value.
- R10: A recognised word whose funct7 is not listed in R2 drives illegal=1, res=0 and res_vld=0.
- R11: With REG_OUT=1, the outputs reflect the word sampled at the previous clock edge. During and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| insn | input | 32 | R-type instruction word |
| op_a | input | XLEN | First source operand |
| op_b | input | XLEN | Second source operand (subtrahend) |
| sat_clr | input | 1 | Clears the sticky saturation bit |
| res | output | XLEN | Packed lane result |
| res_vld | output | 1 | Result belongs to a legal instruction |
| illegal | output | 1 | Recognised word with an unlisted funct7 |
| sat_flag | output | 1 | Sticky saturation bit |

## Verification
One directed operand pair applies the four corner lanes 0xFF+0xFF, 0x00-0x01, 0x80-0x01 and 0x7F+0x01 to all ten operations. This separates wrap from halving from clamping, signed from unsigned handling, and add from subtract, because each corner gives a different byte in each flavour. Random operands with random listed, unlisted and non-matching instruction words check lane independence and the decode boundaries against a wider-precision per-lane model. Directed sequences of clear pulses against clamping and non-clamping operations show the sticky bit's set-over-clear priority and its hold behaviour.

// File: rtl/simd8_pkg.sv
package simd8_pkg;

   localparam logic [6:0] OPC_PACKED = 7'b1110111;
   localparam logic [2:0] F3_BYTE    = 3'b000;

   typedef enum logic [2:0] {
      M_WRAP  = 3'd0,
      M_SHALF = 3'd1,
      M_UHALF = 3'd2,
      M_SSAT  = 3'd3,
      M_USAT  = 3'd4
   } lane_mode_e;

   typedef struct packed {
      logic       match;
      logic       legal;
      logic       is_sub;
      lane_mode_e mode;
   } dec_t;

   function automatic logic mode_saturates(lane_mode_e m);
      return (m == M_SSAT) || (m == M_USAT);
   endfunction

endpackage

// File: rtl/simd8_decode.sv
module simd8_decode
   import simd8_pkg::*;
(
   input  logic [6:0] opcode,
   input  logic [2:0] funct3,
   input  logic [6:0] funct7,
   output dec_t       dec
);

   logic       hit;
   logic       known;
   lane_mode_e mode;

   always_comb begin
      known = 1'b1;
      mode  = M_WRAP;
      unique case (funct7[6:1])
         6'b010010: mode = M_WRAP;
         6'b000010: mode = M_SHALF;
         6'b001010: mode = M_UHALF;
         6'b000110: mode = M_SSAT;
         6'b001110: mode = M_USAT;
         default: begin
            known = 1'b0;
            mode  = M_WRAP;
         end
      endcase
   end

   assign hit        = (opcode == OPC_PACKED) && (funct3 == F3_BYTE);
   assign dec.match  = hit;
   assign dec.legal  = hit && known;
   assign dec.is_sub = funct7[0];
   assign dec.mode   = mode;

endmodule

// File: rtl/simd8_lane.sv
module simd8_lane
   import simd8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         is_sub,
   input  lane_mode_e   mode,
   output logic [W-1:0] y,
   output logic         clamp
);

   localparam int EW = W + 2;

   logic          sgn;
   logic [EW-1:0] ea;
   logic [EW-1:0] eb;
   logic [EW-1:0] ex;
   logic [EW-W:0] top_s;
   logic [1:0]    top_u;
   logic          s_out_of_range;
   logic          u_out_of_range;

   assign sgn = (mode == M_SHALF) || (mode == M_SSAT);
   assign ea  = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
   assign eb  = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
   assign ex  = is_sub ? (ea - eb) : (ea + eb);

   assign top_s          = ex[EW-1:W-1];
   assign top_u          = ex[EW-1:W];
   assign s_out_of_range = !((&top_s) || !(|top_s));
   assign u_out_of_range = |top_u;

   always_comb begin
      y     = ex[W-1:0];
      clamp = 1'b0;
      unique case (mode)
         M_WRAP: y = ex[W-1:0];
         M_SHALF,
         M_UHALF: y = ex[W:1];
         M_SSAT: begin
            clamp = s_out_of_range;
            if (s_out_of_range)
               y = ex[EW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
         end
         M_USAT: begin
            clamp = u_out_of_range;
            if (u_out_of_range)
               y = ex[EW-1] ? {W{1'b0}} : {W{1'b1}};
         end
         default: y = ex[W-1:0];
      endcase
   end

endmodule

// File: rtl/simd8_stickyflag.sv
module simd8_stickyflag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

endmodule

// File: rtl/simd8_addsub.sv
module simd8_addsub
   import simd8_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int LANE_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  logic            sat_clr,
   output logic [XLEN-1:0] res,
   output logic            res_vld,
   output logic            illegal,
   output logic            sat_flag
);

   localparam int LANES = XLEN / LANE_W;

   generate
      if ((XLEN != 32) && (XLEN != 64)) begin : g_bad_xlen
         $error("simd8_addsub: XLEN must be 32 or 64");
      end
      if (LANE_W != 8) begin : g_bad_lane
         $error("simd8_addsub: lanes are 8 bits wide");
      end
   endgenerate

   dec_t            dec;
   logic [XLEN-1:0] lane_res;
   logic [LANES-1:0] lane_clamp;
   logic            take;
   logic            sat_event;
   logic [XLEN-1:0] res_nx;
   logic            vld_nx;
   logic            ill_nx;
   logic            unused_fields;

   assign unused_fields = ^{insn[24:15], insn[11:7]};

   simd8_decode u_dec (
      .opcode (insn[6:0]),
      .funct3 (insn[14:12]),
      .funct7 (insn[31:25]),
      .dec    (dec)
   );

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         simd8_lane #(.W(LANE_W)) u_lane (
            .a      (op_a[gi*LANE_W +: LANE_W]),
            .b      (op_b[gi*LANE_W +: LANE_W]),
            .is_sub (dec.is_sub),
            .mode   (dec.mode),
            .y      (lane_res[gi*LANE_W +: LANE_W]),
            .clamp  (lane_clamp[gi])
         );
      end
   endgenerate

   assign take      = issue && dec.legal;
   assign sat_event = take && mode_saturates(dec.mode) && (|lane_clamp);
   assign res_nx    = take ? lane_res : '0;
   assign vld_nx    = take;
   assign ill_nx    = issue && dec.match && !dec.legal;

   simd8_stickyflag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sat_event),
      .clr_i  (sat_clr),
      .flag_o (sat_flag)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res     <= '0;
               res_vld <= 1'b0;
               illegal <= 1'b0;
            end else begin
               res     <= res_nx;
               res_vld <= vld_nx;
               illegal <= ill_nx;
            end
         end
      end else begin : g_comb_out
         assign res     = res_nx;
         assign res_vld = vld_nx;
         assign illegal = ill_nx;
      end
   endgenerate

endmodule

// File: rtl/simd8_addsub_chk.sv
module simd8_addsub_chk #(
   parameter int XLEN    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue,
   input logic            sat_clr,
   input logic            sat_event,
   input logic [XLEN-1:0] res,
   input logic            res_vld,
   input logic            illegal,
   input logic            sat_flag
);

   AST_ILLEGAL_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (res == '0)); // R10

   AST_VLD_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal && res_vld)); // R10

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      sat_event |=> sat_flag); // R8

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag); // R9

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !sat_event) |=> !sat_flag); // R9

   AST_FLAG_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && !sat_event) |=> !sat_flag); // R8

   generate
      if (REG_OUT) begin : g_lat
         AST_QUIET_WITHOUT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            !issue |=> (!res_vld && !illegal && (res == '0))); // R1
      end
   endgenerate

endmodule

bind simd8_addsub simd8_addsub_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue     (issue),
   .sat_clr   (sat_clr),
   .sat_event (sat_event),
   .res       (res),
   .res_vld   (res_vld),
   .illegal   (illegal),
   .sat_flag  (sat_flag)
);

// File: tb/simd8_addsub_test.sv
`timescale 1ns/100ps
module simd8_addsub_test;

   localparam int XL = 32;
   localparam int NL = XL / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue = 1'b0;
   logic [31:0]   insn = '0;
   logic [XL-1:0] op_a = '0;
   logic [XL-1:0] op_b = '0;
   logic          sat_clr = 1'b0;
   logic [XL-1:0] res;
   logic          res_vld;
   logic          illegal;
   logic          sat_flag;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  exp_flag = 1'b0;

   always #2.5 clk = ~clk;

   simd8_addsub #(.XLEN(XL)) uut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
      .op_a(op_a), .op_b(op_b), .sat_clr(sat_clr),
      .res(res), .res_vld(res_vld), .illegal(illegal), .sat_flag(sat_flag)
   );

   function automatic logic [6:0] f7_of(int k);
      logic [6:0] t [0:4];
      t[0] = 7'b0100100; t[1] = 7'b0000100; t[2] = 7'b0010100;
      t[3] = 7'b0001100; t[4] = 7'b0011100;
      return t[k % 5] | ((k >= 5) ? 7'b0000001 : 7'b0000000);
   endfunction

   function automatic string tag_of(int k);
      case (k % 5)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         default: return "R7";
      endcase
   endfunction

   // returns {clamped, byte}
   function automatic logic [8:0] ref_lane(int k, logic [7:0] a, logic [7:0] b);
      int sa, sb, ua, ub, v, m;
      bit sub, c;
      sa = int'($signed(a)); sb = int'($signed(b));
      ua = int'(a); ub = int'(b);
      sub = (k >= 5); m = k % 5; c = 1'b0;
      case (m)
         0: v = sub ? ua - ub : ua + ub;
         1: v = (sub ? sa - sb : sa + sb) >>> 1;
         2: v = (sub ? ua - ub : ua + ub) >>> 1;
         3: begin
            v = sub ? sa - sb : sa + sb;
            if (v > 127) begin v = 127; c = 1'b1; end
            if (v < -128) begin v = -128; c = 1'b1; end
         end
         default: begin
            v = sub ? ua - ub : ua + ub;
            if (v > 255) begin v = 255; c = 1'b1; end
            if (v < 0) begin v = 0; c = 1'b1; end
         end
      endcase
      return {c, v[7:0]};
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
      return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
   endfunction

   // kind: 0..9 legal code k; 10 unlisted funct7; 11 no match
   task automatic run_op(logic [31:0] w, int kind, logic [XL-1:0] a,
                         logic [XL-1:0] b, bit clr, bit iss);
      logic [XL-1:0] e_res;
      bit e_vld, e_ill, any;
      logic [8:0] r;
      string t;
      @(negedge clk);
      issue = iss; insn = w; op_a = a; op_b = b; sat_clr = clr;
      e_res = '0; e_vld = 1'b0; e_ill = 1'b0; any = 1'b0;
      t = "R1";
      if (iss && kind < 10) begin
         for (int l = 0; l < NL; l++) begin
            r = ref_lane(kind, a[l*8 +: 8], b[l*8 +: 8]);
            e_res[l*8 +: 8] = r[7:0];
            any = any | r[8];
         end
         e_vld = 1'b1;
         t = tag_of(kind);
      end else if (iss && kind == 10) begin
         e_ill = 1'b1;
         t = "R10";
      end
      if (any) exp_flag = 1'b1;
      else if (clr) exp_flag = 1'b0;
      @(posedge clk); #1;
      check(t, 64'(res), 64'(e_res));
      check((kind < 10 && iss) ? "R2" : t, {62'd0, res_vld, illegal}, {62'd0, e_vld, e_ill});
      check((kind % 5 >= 3 && kind < 10) ? "R8" : "R9", 64'(sat_flag), 64'(exp_flag));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1;
      check("R11", {res, 3'b0, res_vld, illegal, sat_flag}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R11", {res, 3'b0, res_vld, illegal, sat_flag}, 64'd0);

      // corner lanes on every variant
      for (int k = 0; k < 10; k++)
         run_op(mk(f7_of(k), 3'b000, 7'b1110111), k, 32'h7F8000FF, 32'h010101FF, 1'b0, 1'b1);

      // R9: clear with no clamp, then set wins over clear, then hold
      run_op(mk(f7_of(0), 3'b000, 7'b1110111), 0, 32'hFFFFFFFF, 32'h01010101, 1'b1, 1'b1);
      check("R9", 64'(sat_flag), 64'd0);
      run_op(mk(f7_of(8), 3'b000, 7'b1110111), 8, 32'h80000000, 32'h01000000, 1'b1, 1'b1);
      check("R9", 64'(sat_flag), 64'd1);
      run_op(mk(f7_of(1), 3'b000, 7'b1110111), 1, 32'h12345678, 32'h11111111, 1'b0, 1'b1);
      check("R9", 64'(sat_flag), 64'd1);
      // R8: wrap and halving overflow never set the bit
      run_op(mk(f7_of(4), 3'b000, 7'b1110111), 4, 32'h01020304, 32'h01010101, 1'b1, 1'b1);
      run_op(mk(f7_of(0), 3'b000, 7'b1110111), 0, 32'hFFFF8000, 32'hFFFF8001, 1'b0, 1'b1);
      run_op(mk(f7_of(7), 3'b000, 7'b1110111), 7, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b1);
      check("R8", 64'(sat_flag), 64'd0);
      // R11: idle cycle returns outputs to zero
      run_op(mk(f7_of(0), 3'b000, 7'b1110111), 11, 32'h11111111, 32'h11111111, 1'b0, 1'b0);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int sel;
         logic [6:0] bad [0:3];
         logic [XL-1:0] ra, rb;
         bit rc;
         bad[0] = 7'b0100110; bad[1] = 7'b1111111; bad[2] = 7'b0000000; bad[3] = 7'b0010110;
         ra = $urandom; rb = $urandom;
         rc = ($urandom % 8) == 0;
         sel = $urandom % 21;
         if (sel < 16)
            run_op(mk(f7_of(sel % 10), 3'b000, 7'b1110111), sel % 10, ra, rb, rc, 1'b1);
         else if (sel < 18)
            run_op(mk(bad[$urandom % 4], 3'b000, 7'b1110111), 10, ra, rb, rc, 1'b1);
         else if (sel == 18)
            run_op(mk(f7_of(3), 3'b010, 7'b1110111), 11, ra, rb, rc, 1'b1);
         else if (sel == 19)
            run_op(mk(f7_of(3), 3'b000, 7'b1110011), 11, ra, rb, rc, 1'b1);
         else
            run_op(mk(f7_of(3), 3'b000, 7'b1110111), 11, ra, rb, rc, 1'b0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule